// File: doc/BRIEF.md
# Configuration Address/Data Window Bridge

The bridge gives a host two register ports for reaching the configuration space of devices behind it. A 32-bit address port holds a latched selector: bus number, device, function and register offset, plus a window-enable flag in the top bit. A second port, the data window, turns each access into a single-cycle configuration read or write on a downstream interface. The downstream side sees the decoded bus, device, function and byte offset along with the access size.

Data-window accesses only reach downstream while the enable flag is set. A disabled window, or a target that reports itself absent, reads as all ones cut to the access width. The two low address bits of a data-window access are OR'ed into the latched offset, so that narrow accesses can reach every byte lane of a dword. Every read, whatever its source, answers with a fixed three-cycle latency, so responses come back in issue order. A new request may be issued every cycle.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the address register is zero. A 4-byte data-window read returns 0xFFFFFFFF and raises no downstream request.
- R2: A 4-byte (`host_size`=2'b10) write to the address port (`host_sel`=0) stores all 32 bits. A later 4-byte read of that port returns the value unchanged, with `host_rvalid` high exactly 3 cycles after the request cycle.
- R3: An address-port access of 1 byte (2'b00), 2 bytes (2'b01) or the reserved size 2'b11 is ignored. A write leaves the register unchanged and a read produces no `host_rvalid`.
- R4: While bit 31 of the address register is 0, a data-window (`host_sel`=1) write raises no `dn_req`. A data-window read returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for sizes 2'b00, 2'b01 and 2'b10.
- R5: While bit 31 is 1, a data-window access raises `dn_req` for exactly one cycle, in the cycle after the request. It drives `dn_bus`=addr[23:16], `dn_dev`=addr[15:11], `dn_fn`=addr[10:8] and copies the size.
- R6: `dn_off` equals {addr[7:2], addr[1:0] OR `host_lo`}.
- R7: Bits 30:24 of the address register are read back but have no effect on any downstream field.
- R8: `dn_present` and `dn_rdata` are sampled in the cycle after `dn_req`. A present target's data is returned right-justified, with the bytes above the access width forced to zero.
- R9: When `dn_present` is low, the read returns all ones masked to the access width, whatever `dn_rdata` holds.
- R10: `dn_we` follows `host_we`, and on writes `dn_wdata` equals `host_wdata` unchanged.
- R11: A data-window access with the reserved size 2'b11 raises no `dn_req` and no `host_rvalid`.
- R12: A data-window access in the cycle right after an address-port write uses the newly written address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_sel | input | 1 | 0 selects the address port, 1 the data window |
| host_we | input | 1 | 1 for write, 0 for read |
| host_lo | input | 2 | Low two bits of the host access address |
| host_size | input | 2 | 00 one byte, 01 two bytes, 10 four bytes, 11 reserved |
| host_wdata | input | 32 | Host write data, right-justified |
| host_rvalid | output | 1 | Read data valid, one cycle |
| host_rdata | output | 32 | Read data, right-justified |
| dn_req | output | 1 | Downstream configuration request strobe |
| dn_we | output | 1 | Downstream request is a write |
| dn_bus | output | 8 | Target bus number |
| dn_dev | output | 5 | Target device number |
| dn_fn | output | 3 | Target function number |
| dn_off | output | 8 | Register byte offset |
| dn_size | output | 2 | Access size, same encoding as host_size |
| dn_wdata | output | 32 | Downstream write data |
| dn_present | input | 1 | Target answered, valid the cycle after dn_req |
| dn_rdata | input | 32 | Target read data, valid the cycle after dn_req |

## Verification
The hardest case to reach is a data-window access issued in the very cycle after an address-port write. It must see the new selector, even though the register changes at that same edge. The bench drives the two requests on consecutive clocks and then checks the decoded fields and the returned data. A second hard case is an absent target. The bench's downstream model drives a non-ones data pattern on `dn_rdata` with `dn_present` low, so the all-ones result can only come from the bridge's own substitution.

// File: rtl/cfgwin_pkg.sv
`timescale 1ns/1ps
package cfgwin_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned OFF_W   = 8;
  localparam int unsigned FN_W    = 3;
  localparam int unsigned DEV_W   = 5;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned LO_W    = 2;
  localparam int unsigned OFF_LSB = 0;
  localparam int unsigned FN_LSB  = OFF_LSB + OFF_W;
  localparam int unsigned DEV_LSB = FN_LSB + FN_W;
  localparam int unsigned BUS_LSB = DEV_LSB + DEV_W;
  localparam int unsigned EN_POS  = WORD_W - 1;

  typedef enum logic [1:0] {
    SZ_B1  = 2'b00,
    SZ_B2  = 2'b01,
    SZ_B4  = 2'b10,
    SZ_RSV = 2'b11
  } acc_size_e;
endpackage

// File: rtl/cfgwin_addr_reg.sv
`timescale 1ns/1ps
module cfgwin_addr_reg
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] addr_q
);
  logic [WORD_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_en) addr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= addr_d;
  end
endmodule

// File: rtl/cfgwin_fwd.sv
`timescale 1ns/1ps
module cfgwin_fwd
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              we,
  input  logic [LO_W-1:0]   lo,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] addr_q,
  output logic              dn_req,
  output logic              dn_we,
  output logic [BUS_W-1:0]  dn_bus,
  output logic [DEV_W-1:0]  dn_dev,
  output logic [FN_W-1:0]   dn_fn,
  output logic [OFF_W-1:0]  dn_off,
  output logic [1:0]        dn_size,
  output logic [WORD_W-1:0] dn_wdata
);
  logic [OFF_W-1:0] off_d;
  logic [BUS_W-1:0] bus_d;
  logic [DEV_W-1:0] dev_d;
  logic [FN_W-1:0]  fn_d;

  always_comb begin
    off_d = addr_q[OFF_LSB +: OFF_W] | {{(OFF_W-LO_W){1'b0}}, lo};
    bus_d = addr_q[BUS_LSB +: BUS_W];
    dev_d = addr_q[DEV_LSB +: DEV_W];
    fn_d  = addr_q[FN_LSB +: FN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dn_req <= 1'b0;
    else        dn_req <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_we    <= 1'b0;
      dn_bus   <= '0;
      dn_dev   <= '0;
      dn_fn    <= '0;
      dn_off   <= '0;
      dn_size  <= '0;
      dn_wdata <= '0;
    end else if (fire) begin
      dn_we    <= we;
      dn_bus   <= bus_d;
      dn_dev   <= dev_d;
      dn_fn    <= fn_d;
      dn_off   <= off_d;
      dn_size  <= size;
      dn_wdata <= wdata;
    end
  end
endmodule

// File: rtl/cfgwin_rsp.sv
`timescale 1ns/1ps
module cfgwin_rsp
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              is_dev,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] local_val,
  input  logic              dn_present,
  input  logic [WORD_W-1:0] dn_rdata,
  output logic              rvalid,
  output logic [WORD_W-1:0] rdata
);
  logic              p1_vld, p2_vld;
  logic              p1_dev, p2_dev;
  logic [1:0]        p1_size, p2_size;
  logic [WORD_W-1:0] p1_val, p2_val;
  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] out_d;
  logic [3:0]        nbytes;

  always_comb begin
    nbytes = 4'd1 << p2_size;
    if (p2_dev) raw = dn_present ? dn_rdata : '1;
    else        raw = p2_val;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign out_d[8*b +: 8] = (4'(b) < nbytes) ? raw[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_vld <= 1'b0;
      p2_vld <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      p1_vld <= issue;
      p2_vld <= p1_vld;
      rvalid <= p2_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_dev <= 1'b0; p1_size <= '0; p1_val <= '0;
    end else if (issue) begin
      p1_dev <= is_dev; p1_size <= size; p1_val <= local_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2_dev <= 1'b0; p2_size <= '0; p2_val <= '0;
    end else if (p1_vld) begin
      p2_dev <= p1_dev; p2_size <= p1_size; p2_val <= p1_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (p2_vld) rdata <= out_d;
  end
endmodule

// File: rtl/cfg_window_bridge.sv
`timescale 1ns/1ps
module cfg_window_bridge
  import cfgwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_sel,
  input  logic        host_we,
  input  logic [1:0]  host_lo,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic        host_rvalid,
  output logic [31:0] host_rdata,
  output logic        dn_req,
  output logic        dn_we,
  output logic [7:0]  dn_bus,
  output logic [4:0]  dn_dev,
  output logic [2:0]  dn_fn,
  output logic [7:0]  dn_off,
  output logic [1:0]  dn_size,
  output logic [31:0] dn_wdata,
  input  logic        dn_present,
  input  logic [31:0] dn_rdata
);
  logic [WORD_W-1:0] cfg_addr_q;
  logic              addr_acc, data_acc, win_en;
  logic              addr_wr, dn_fire, rd_issue;
  logic [1:0]        rd_size;
  logic [WORD_W-1:0] rd_local;

  always_comb begin
    addr_acc = host_req && !host_sel && (host_size == SZ_B4);
    data_acc = host_req &&  host_sel && (host_size != SZ_RSV);
    win_en   = cfg_addr_q[EN_POS];
    addr_wr  = addr_acc && host_we;
    dn_fire  = data_acc && win_en;
    rd_issue = (addr_acc || data_acc) && !host_we;
    rd_size  = addr_acc ? SZ_B4 : host_size;
    rd_local = addr_acc ? cfg_addr_q : '1;
  end

  cfgwin_addr_reg u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (addr_wr),
    .wr_data (host_wdata),
    .addr_q  (cfg_addr_q)
  );

  cfgwin_fwd u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (dn_fire),
    .we       (host_we),
    .lo       (host_lo),
    .size     (host_size),
    .wdata    (host_wdata),
    .addr_q   (cfg_addr_q),
    .dn_req   (dn_req),
    .dn_we    (dn_we),
    .dn_bus   (dn_bus),
    .dn_dev   (dn_dev),
    .dn_fn    (dn_fn),
    .dn_off   (dn_off),
    .dn_size  (dn_size),
    .dn_wdata (dn_wdata)
  );

  cfgwin_rsp u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (rd_issue),
    .is_dev     (dn_fire),
    .size       (rd_size),
    .local_val  (rd_local),
    .dn_present (dn_present),
    .dn_rdata   (dn_rdata),
    .rvalid     (host_rvalid),
    .rdata      (host_rdata)
  );
endmodule

// File: rtl/cfgwin_chk.sv
`timescale 1ns/1ps
module cfgwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_req,
  input logic        host_sel,
  input logic        host_we,
  input logic [1:0]  host_size,
  input logic        dn_req,
  input logic [7:0]  dn_off,
  input logic        host_rvalid,
  input logic [31:0] host_rdata,
  input logic [31:0] addr_q
);
  // R5
  fwd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> $past(host_req && host_sel && (host_size != 2'b11) && addr_q[31]));

  // R6
  offset_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (dn_off[7:2] == $past(addr_q[7:2])));

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_req && !host_we, 3));

  // R3
  narrow_addr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_sel && host_we && (host_size != 2'b10)) |=> $stable(addr_q));

  // R4
  byte_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(host_sel && (host_size == 2'b00), 3)) |-> (host_rdata[31:8] == 24'h0));
endmodule

bind cfg_window_bridge cfgwin_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_req    (host_req),
  .host_sel    (host_sel),
  .host_we     (host_we),
  .host_size   (host_size),
  .dn_req      (dn_req),
  .dn_off      (dn_off),
  .host_rvalid (host_rvalid),
  .host_rdata  (host_rdata),
  .addr_q      (cfg_addr_q)
);

// File: tb/cfg_window_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_window_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_sel, host_we;
  logic [1:0]  host_lo, host_size;
  logic [31:0] host_wdata;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        dn_req, dn_we;
  logic [7:0]  dn_bus, dn_off;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_fn;
  logic [1:0]  dn_size;
  logic [31:0] dn_wdata;
  logic        dn_present;
  logic [31:0] dn_rdata;

  int checks = 0;
  int errors = 0;
  int wd     = 0;

  // sampled results of the last access
  logic        s_req1, s_req2, s_rv2, s_rv3, s_rv4, s_we;
  logic [7:0]  s_bus, s_off;
  logic [4:0]  s_dev;
  logic [2:0]  s_fn;
  logic [1:0]  s_size;
  logic [31:0] s_wdata, s_rdata;

  always #2 clk = ~clk;

  cfg_window_bridge dut_i (.*);

  // downstream target model: devices 0..3 present, answer one cycle after request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_present <= 1'b0;
      dn_rdata   <= 32'h0;
    end else begin
      dn_present <= dn_req && (dn_dev < 5'd4);
      dn_rdata   <= dn_req ? {8'h9E, dn_bus, dn_off, dn_dev, dn_fn} : 32'h0BAD0BAD;
    end
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 50000) begin
      errors++;
      $display("FAIL timeout all-reqs actual=%0d expected=<50000", wd);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input logic [1:0] sz, input logic [31:0] v);
    case (sz)
      2'b00:   return v & 32'h0000_00FF;
      2'b01:   return v & 32'h0000_FFFF;
      default: return v;
    endcase
  endfunction

  task automatic issue(input logic sel, input logic we, input logic [1:0] lo,
                       input logic [1:0] sz, input logic [31:0] wd_v);
    @(negedge clk);
    host_req = 1'b1; host_sel = sel; host_we = we;
    host_lo = lo; host_size = sz; host_wdata = wd_v;
    @(negedge clk);
    host_req = 1'b0;
    s_req1 = dn_req; s_we = dn_we; s_bus = dn_bus; s_dev = dn_dev; s_fn = dn_fn;
    s_off = dn_off; s_size = dn_size; s_wdata = dn_wdata;
    @(negedge clk);
    s_req2 = dn_req; s_rv2 = host_rvalid;
    @(negedge clk);
    s_rv3 = host_rvalid; s_rdata = host_rdata;
    @(negedge clk);
    s_rv4 = host_rvalid;
  endtask

  task automatic t_reset;
    issue(1'b0, 1'b0, 2'b00, 2'b10, 32'h0);
    chk("R1 addr reg after reset", s_rdata, 32'h0);
    issue(1'b1, 1'b0, 2'b00, 2'b10, 32'h0);
    chk("R1 no dn_req after reset", {31'h0, s_req1}, 32'h0);
    chk("R1 data read after reset", s_rdata, 32'hFFFF_FFFF);
  endtask

  task automatic t_addr_port;
    issue(1'b0, 1'b1, 2'b00, 2'b10, 32'h7F5A_C3E1);
    issue(1'b0, 1'b0, 2'b00, 2'b10, 32'h0);
    chk("R2 rvalid not early", {30'h0, s_req2, s_rv2}, 32'h0);
    chk("R2 rvalid at cycle 3", {31'h0, s_rv3}, 32'h1);
    chk("R2 rvalid one cycle", {31'h0, s_rv4}, 32'h0);
    chk("R2 R7 readback", s_rdata, 32'h7F5A_C3E1);
    issue(1'b0, 1'b1, 2'b00, 2'b00, 32'h1111_1111);
    issue(1'b0, 1'b1, 2'b00, 2'b11, 32'h2222_2222);
    issue(1'b0, 1'b0, 2'b00, 2'b01, 32'h0);
    chk("R3 narrow read no response", {31'h0, s_rv3}, 32'h0);
    issue(1'b0, 1'b0, 2'b00, 2'b10, 32'h0);
    chk("R3 narrow writes ignored", s_rdata, 32'h7F5A_C3E1);
  endtask

  task automatic t_disabled;
    issue(1'b0, 1'b1, 2'b00, 2'b10, 32'h0001_0800);
    issue(1'b1, 1'b1, 2'b00, 2'b10, 32'hCAFE_F00D);
    chk("R4 disabled write no dn_req", {30'h0, s_req1, s_req2}, 32'h0);
    for (int sz = 0; sz < 3; sz++) begin
      issue(1'b1, 1'b0, 2'b01, 2'(sz), 32'h0);
      chk("R4 disabled read ones", s_rdata, msk(2'(sz), 32'hFFFF_FFFF));
    end
  endtask

  task automatic t_enabled;
    // bus 05, dev 3, fn 2, offset 0x40, bits 30:24 = 0x3C
    issue(1'b0, 1'b1, 2'b00, 2'b10, 32'hBC05_1A40);
    issue(1'b1, 1'b1, 2'b00, 2'b10, 32'hDEAD_BEEF);
    chk("R5 dn_req one cycle", {30'h0, s_req1, s_req2}, 32'h2);
    chk("R5 R7 decode fields", {8'h0, s_bus, 3'h0, s_dev, 5'h0, s_fn}, {8'h0, 8'h05, 3'h0, 5'd3, 5'h0, 3'd2});
    chk("R5 size copied", {30'h0, s_size}, 32'h2);
    chk("R10 write data", s_wdata, 32'hDEAD_BEEF);
    chk("R10 write flag", {31'h0, s_we}, 32'h1);
    chk("R6 offset lo=0", {24'h0, s_off}, 32'h40);
    issue(1'b1, 1'b0, 2'b11, 2'b00, 32'h0);
    chk("R6 offset lo=3", {24'h0, s_off}, 32'h43);
    chk("R10 read flag", {31'h0, s_we}, 32'h0);
    chk("R8 byte read", s_rdata, msk(2'b00, {8'h9E, 8'h05, 8'h43, 5'd3, 3'd2}));
    issue(1'b0, 1'b1, 2'b00, 2'b10, 32'h8005_1A41);
    issue(1'b1, 1'b0, 2'b10, 2'b01, 32'h0);
    chk("R6 offset OR fold", {24'h0, s_off}, 32'h43);
    chk("R8 half read", s_rdata, msk(2'b01, {8'h9E, 8'h05, 8'h43, 5'd3, 3'd2}));
    issue(1'b1, 1'b0, 2'b00, 2'b10, 32'h0);
    chk("R8 word read", s_rdata, {8'h9E, 8'h05, 8'h41, 5'd3, 3'd2});
    issue(1'b1, 1'b0, 2'b00, 2'b11, 32'h0);
    chk("R11 reserved size no dn_req", {31'h0, s_req1}, 32'h0);
    chk("R11 reserved size no rvalid", {31'h0, s_rv3}, 32'h0);
  endtask

  task automatic t_absent;
    // device 9 is absent in the model
    issue(1'b0, 1'b1, 2'b00, 2'b10, 32'h8007_4810);
    issue(1'b1, 1'b0, 2'b00, 2'b01, 32'h0);
    chk("R9 absent dn_req raised", {31'h0, s_req1}, 32'h1);
    chk("R9 absent half read", s_rdata, 32'h0000_FFFF);
    issue(1'b1, 1'b0, 2'b00, 2'b10, 32'h0);
    chk("R9 absent word read", s_rdata, 32'hFFFF_FFFF);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    host_req = 1'b1; host_sel = 1'b0; host_we = 1'b1;
    host_lo = 2'b00; host_size = 2'b10; host_wdata = 32'h8022_1308;
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_lo = 2'b01; host_size = 2'b10;
    @(negedge clk);
    host_req = 1'b0;
    chk("R12 dn_req uses new addr", {31'h0, dn_req}, 32'h1);
    chk("R12 new bus/dev/fn/off", {dn_bus, 3'h0, dn_dev, 5'h0, dn_fn, dn_off},
        {8'h22, 3'h0, 5'd2, 5'h0, 3'd3, 8'h09});
    @(negedge clk);
    @(negedge clk);
    chk("R12 read data", host_rdata, {8'h9E, 8'h22, 8'h09, 5'd2, 3'd3});
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    host_req = 1'b0; host_sel = 1'b0; host_we = 1'b0;
    host_lo = 2'b00; host_size = 2'b00; host_wdata = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 no dn_req in reset", {31'h0, dn_req}, 32'h0);
    chk("R1 no rvalid in reset", {31'h0, host_rvalid}, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_addr_port();
    t_disabled();
    t_enabled();
    t_absent();
    t_back_to_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule